// File: doc/BRIEF.md
# Nonvolatile Byte Array Erase/Program Sequencer

This block stands between a byte-wide processor bus and a small nonvolatile byte array (modelled as registers that come up erased). Software controls it through one control register holding three bits: a latch bit, an erase-select bit and a program-enable bit. With the latch bit clear the array behaves as plain read-only memory. With the latch bit set, the first array write is taken as the target address and data of an operation. Setting the program-enable bit then runs a timed pulse of `PULSE_CYCLES` clocks. At the end of the pulse the target byte is erased to all ones or programmed (bits cleared).

A sequencer with five named states runs the operation. **S_IDLE**: latch clear. **S_ARMED**: latched, with no target captured. **S_HELD**: target captured. **S_PULSE**: pulse running. **S_DONE**: pulse finished, waiting for the latch bit to clear. The transitions are as follows. *drop*: a control write with the latch bit 0 goes from any state to S_IDLE. *arm*: S_IDLE goes to S_ARMED on a control write with the latch bit 1. *capture*: S_ARMED goes to S_HELD on an array write. *start*: a control write that raises program-enable goes from S_IDLE, S_ARMED or S_HELD to S_PULSE. *expire*: S_PULSE goes to S_DONE when the count runs out. *abort*: a control write that clears program-enable goes from S_PULSE back to S_HELD, or to S_ARMED if no target was captured.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset the control register reads 0, and busy and pump_on are 0.
- R2: While the latch bit is 0, writes to erase-select and program-enable have no effect: both read back 0 and pump_on stays 0.
- R3: While the latch bit is 0, an array read returns the stored byte and an array write changes nothing.
- R4: While the latch bit is 1, every array read returns 8'hFF.
- R5: With the latch bit 1, the first array write captures address and data. Later array writes are ignored until the latch bit is cleared and set again.
- R6: A control write that raises program-enable with the latch bit 1 raises busy and pump_on on the next cycle. Both stay high for exactly PULSE_CYCLES cycles.
- R7: When a pulse expires with erase-select 0, the captured byte becomes old AND captured data.
- R8: When a pulse expires with erase-select 1, the captured byte becomes 8'hFF, whatever data was written.
- R9: Clearing program-enable during a pulse drops busy on the next cycle and leaves the array unchanged.
- R10: pump_on is 0 whenever program-enable is 0.
- R11: Address bit 8 = 1 selects the control register and 0 selects array byte bus_addr[7:0]. The control register reads back {5'b0, latch, erase-select, program-enable} in bits [2:0]. bus_rdata is 0 when bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Bit 8 selects the control register, bits 7:0 the array byte |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| busy | output | 1 | High while a pulse runs |
| pump_on | output | 1 | High-voltage enable, program-enable qualified |

## Verification
The bench programs bytes whose old and new patterns overlap partly, so AND-merging shows up as a different result from plain overwriting. It erases with all-zero data, which shows that the data is ignored. It issues two array writes within one latch session to tell first-write capture from last-write capture. It aborts a pulse part-way through to separate commit-on-expiry from early commit. Writes to the control register with the latch bit clear, and reads while latched, exercise the interlock and the forced 8'hFF read path.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_HELD,
        S_PULSE,
        S_DONE
    } nvm_state_e;

    localparam int BIT_LAT = 2;
    localparam int BIT_ERA = 1;
    localparam int BIT_PGM = 0;
endpackage

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
    import nvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wbits,
    output logic       lat,
    output logic       era,
    output logic       pgm
);
    // Erase-select and program-enable can only be set together with the latch bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat <= 1'b0;
            era <= 1'b0;
            pgm <= 1'b0;
        end else if (wr) begin
            lat <= wbits[BIT_LAT];
            era <= wbits[BIT_LAT] & wbits[BIT_ERA];
            pgm <= wbits[BIT_LAT] & wbits[BIT_PGM];
        end
    end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int PULSE_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [2:0] wbits,
    input  logic       pgm_q,
    input  logic       arr_wr,
    output logic       cap_en,
    output logic       commit,
    output logic       busy
);
    localparam int CW   = $clog2(PULSE_CYCLES + 1);
    localparam int LAST = PULSE_CYCLES - 1;

    nvm_state_e    state, nxt;
    logic          cap_valid;
    logic [CW-1:0] cnt;
    logic          start, drop, stop, expire;

    assign start  = ctrl_wr & wbits[BIT_LAT] & wbits[BIT_PGM] & ~pgm_q;
    assign drop   = ctrl_wr & ~wbits[BIT_LAT];
    assign stop   = ctrl_wr & ~wbits[BIT_PGM];
    assign expire = (cnt == CW'(LAST));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (drop) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (start) nxt = S_PULSE;
                         else if (ctrl_wr) nxt = S_ARMED;
                S_ARMED: if (start) nxt = S_PULSE;
                         else if (arr_wr) nxt = S_HELD;
                S_HELD:  if (start) nxt = S_PULSE;
                S_PULSE: if (stop) nxt = cap_valid ? S_HELD : S_ARMED;
                         else if (expire) nxt = S_DONE;
                S_DONE:  nxt = S_DONE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || drop) cap_valid <= 1'b0;
        else if (cap_en)    cap_valid <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state != S_PULSE) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    always_comb begin
        cap_en = (state == S_ARMED) & arr_wr;
        commit = (state == S_PULSE) & expire & ~stop & ~drop & cap_valid;
        busy   = (state == S_PULSE);
    end
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (cap_en) begin
            cap_addr <= wr_addr;
            cap_data <= wr_data;
        end
    end

    // Cells start out erased; programming can only clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit) begin
            mem[cap_addr] <= erase ? '1 : (mem[cap_addr] & cap_data);
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
    import nvm_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PULSE_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              pump_on
);
    logic sel_ctrl, ctrl_wr, arr_wr;
    logic ctrl_lat, ctrl_era, ctrl_pgm;
    logic cap_en, commit, seq_busy;
    logic [DATA_W-1:0] arr_q;

    assign sel_ctrl = bus_addr[ADDR_W];
    assign ctrl_wr  = bus_wr & sel_ctrl;
    assign arr_wr   = bus_wr & ~sel_ctrl;

    nvm_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wbits (bus_wdata[2:0]),
        .lat   (ctrl_lat),
        .era   (ctrl_era),
        .pgm   (ctrl_pgm)
    );

    nvm_seq #(.PULSE_CYCLES(PULSE_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wbits   (bus_wdata[2:0]),
        .pgm_q   (ctrl_pgm),
        .arr_wr  (arr_wr),
        .cap_en  (cap_en),
        .commit  (commit),
        .busy    (seq_busy)
    );

    nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .wr_addr (bus_addr[ADDR_W-1:0]),
        .wr_data (bus_wdata),
        .commit  (commit),
        .erase   (ctrl_era),
        .rd_addr (bus_addr[ADDR_W-1:0]),
        .rd_data (arr_q)
    );

    assign busy    = seq_busy;
    assign pump_on = seq_busy & ctrl_pgm;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctrl)      bus_rdata[2:0] = {ctrl_lat, ctrl_era, ctrl_pgm};
            else if (ctrl_lat) bus_rdata = '1;
            else               bus_rdata = arr_q;
        end
    end
endmodule

// File: rtl/nvm_access_chk.sv
module nvm_access_chk #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PULSE_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W:0]   bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              busy,
    input logic              pump_on,
    input logic              pgm_bit
);
    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_run <= 0;
        else                 busy_run <= busy_run + 1;
    end

    assert_pump_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_bit |-> !pump_on);

    assert_interlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[ADDR_W] && !bus_rdata[2]) |-> (bus_rdata[1:0] == 2'b00));

    assert_latched_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[ADDR_W] && pgm_bit && busy) |-> (bus_rdata == '1));

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr[ADDR_W] && !bus_wdata[0]) |=> !busy);

    assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr[ADDR_W] && bus_wdata[2] && bus_wdata[0]));

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= PULSE_CYCLES);

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind nvm_access_ctrl nvm_access_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .pump_on   (pump_on),
    .pgm_bit   (ctrl_pgm)
);

// File: tb/nvm_access_ctrl_tb.sv
module nvm_access_ctrl_tb;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       busy, pump_on;

    int n_vec = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    nvm_access_ctrl #(.PULSE_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .busy(busy), .pump_on(pump_on)
    );

    // Behavioural reference model
    int m_mem [256];
    bit m_lat, m_era, m_pgm, m_capv;
    int m_capa, m_capd, m_phase, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            m_lat = 0; m_era = 0; m_pgm = 0; m_capv = 0;
            m_phase = 0; m_cnt = 0; m_capa = 0; m_capd = 0;
        end else begin
            int ph0;
            ph0 = m_phase;
            if (bus_wr && bus_addr[8]) begin
                if (!bus_wdata[2]) begin
                    m_lat = 0; m_era = 0; m_pgm = 0; m_capv = 0; m_phase = 0;
                end else begin
                    if (bus_wdata[0] && !m_pgm && m_phase == 0) begin
                        m_phase = 1; m_cnt = 0;
                    end else if (!bus_wdata[0] && m_phase == 1) begin
                        m_phase = 0;
                    end
                    m_lat = 1; m_era = bus_wdata[1]; m_pgm = bus_wdata[0];
                end
            end else if (bus_wr && m_lat && !m_capv && m_phase == 0) begin
                m_capv = 1; m_capa = bus_addr[7:0]; m_capd = bus_wdata;
            end
            if (ph0 == 1 && m_phase == 1) begin
                m_cnt++;
                if (m_cnt == N) begin
                    if (m_capv) m_mem[m_capa] = m_era ? 255 : (m_mem[m_capa] & m_capd);
                    m_phase = 2;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] e_rd;
            logic e_busy;
            e_rd = 8'h00;
            if (bus_rd) begin
                if (bus_addr[8]) e_rd = {5'b0, m_lat, m_era, m_pgm};
                else if (m_lat)  e_rd = 8'hFF;
                else             e_rd = m_mem[bus_addr[7:0]][7:0];
            end
            e_busy = (m_phase == 1);
            n_vec++;
            if (bus_rdata !== e_rd || busy !== e_busy || pump_on !== (e_busy && m_pgm)) begin
                n_bad++;
                $display("FAIL %s: rdata=%h busy=%b pump=%b expected rdata=%h busy=%b pump=%b",
                         cur_req, bus_rdata, busy, pump_on, e_rd, e_busy, e_busy && m_pgm);
            end
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle_cyc(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
            bus_wr = 0; bus_rd = 0;
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    // Read stays asserted through the next negedge, where the value is taken.
    task automatic rd(input logic [8:0] a, output int v);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 0; bus_rd = 1;
        @(negedge clk); #1;
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    localparam logic [8:0] CTRL = 9'h100;

    initial begin
        fork
            begin
                #1_000_000;
                n_bad++;
                $display("FAIL watchdog: run did not finish, expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        join_none
    end

    initial begin
        int v, cnt;
        idle_cyc(3);
        rst_n = 1;
        idle_cyc(1);

        cur_req = "R1";
        rd(CTRL, v); chk("R1 ctrl after reset", v, 0);
        chk("R1 busy after reset", busy, 0);

        cur_req = "R2";
        wr(CTRL, 8'h03);
        rd(CTRL, v); chk("R2 interlock", v, 0);

        cur_req = "R3";
        wr(9'h005, 8'h00);
        rd(9'h005, v); chk("R3 unlatched write ignored", v, 8'hFF);

        cur_req = "R7";
        wr(CTRL, 8'h04);
        wr(9'h010, 8'h5A);
        cur_req = "R4";
        rd(9'h010, v); chk("R4 latched read", v, 8'hFF);
        cur_req = "R11";
        rd(CTRL, v); chk("R11 ctrl readback", v, 4);
        cur_req = "R6";
        @(posedge clk); #1;
        bus_addr = CTRL; bus_wdata = 8'h05; bus_wr = 1;
        @(posedge clk); #1;
        bus_wr = 0;
        cnt = 0;
        for (int i = 0; i < N + 4; i++) begin
            @(negedge clk);
            if (busy) cnt++;
        end
        chk("R6 pulse length", cnt, N);
        wr(CTRL, 8'h00);
        cur_req = "R7";
        rd(9'h010, v); chk("R7 program first", v, 8'h5A);

        wr(CTRL, 8'h04);
        wr(9'h010, 8'h0F);
        wr(CTRL, 8'h05);
        idle_cyc(N + 2);
        wr(CTRL, 8'h00);
        rd(9'h010, v); chk("R7 program AND", v, 8'h0A);

        cur_req = "R5";
        wr(CTRL, 8'h04);
        wr(9'h020, 8'h00);
        wr(9'h021, 8'h00);
        wr(CTRL, 8'h05);
        idle_cyc(N + 2);
        wr(CTRL, 8'h00);
        rd(9'h020, v); chk("R5 first captured", v, 8'h00);
        rd(9'h021, v); chk("R5 second ignored", v, 8'hFF);

        cur_req = "R8";
        wr(CTRL, 8'h06);
        rd(CTRL, v); chk("R11 erase-select readback", v, 6);
        wr(9'h010, 8'h00);
        wr(CTRL, 8'h07);
        idle_cyc(N + 2);
        wr(CTRL, 8'h00);
        rd(9'h010, v); chk("R8 erased", v, 8'hFF);

        cur_req = "R9";
        wr(CTRL, 8'h04);
        wr(9'h030, 8'h00);
        wr(CTRL, 8'h05);
        idle_cyc(3);
        chk("R9 busy mid pulse", busy, 1);
        wr(CTRL, 8'h04);
        chk("R9 busy after abort", busy, 0);
        idle_cyc(N + 2);
        wr(CTRL, 8'h00);
        rd(9'h030, v); chk("R9 array unchanged", v, 8'hFF);

        cur_req = "R10";
        chk("R10 pump off", pump_on, 0);
        cur_req = "R3";
        rd(9'h020, v); chk("R3 rom read", v, 8'h00);

        idle_cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule